// File: doc/BRIEF.md
# Parallel Code-Memory Programming Controller

This block runs the parallel programming mode of a small on-chip code memory of 1024 bytes. An external programmer steps through the array with an internal address counter. A level on the reset pin clears the counter. Pulses on a separate increment pin advance it. Four select pins, together with a high-voltage-present flag, choose the operation. Program operations are started by edges on a strobe pin and then time themselves. The memory is held as a register array. Two lock bits limit what the programmer can still do.

A byte write starts on a rising strobe edge and runs for a set number of clock cycles. While it runs, a read returns the byte being written with its top bit inverted, so software can poll for completion. A chip erase starts on a falling strobe edge. It only takes effect if the strobe is still low when its timer runs out. The ready output is low during any timed cycle. Three fixed signature bytes can be read at the bottom three addresses. Every pin is sampled on the block clock.

Top module: `flashprog_ctrl`

## Requirements
- R1: After `rst_n` is released, `rdy` is 1 and `doe` is 0. Every array byte reads FFh and both lock bits are clear.
- R2: A rising edge on `prst_pin` clears the address counter to 0 in the next cycle. This takes priority over an increment seen in the same cycle.
- R3: A rising edge on `incr_pin` raises the address by one. The counter wraps from 1023 to 0.
- R4: `doe` is 1 only when `prst_pin`=1, `hv_flag`=0, `prog_pin`=1 and `msel` is 4'b1100 (code read) or 4'b0000 (signature read). When `doe` is 0, `dout` is 00h. `msel[0]..msel[3]` are select lines a..d.
- R5: With `prst_pin`=1, `hv_flag`=1 and `msel`=4'b1110, a rising edge on `prog_pin` starts a code write. `rdy` is low from the next cycle for exactly WRITE_CYCLES cycles. The byte at the address held at the start becomes its old value AND the `din` sampled at the start.
- R6: While a code write is busy, a code read returns the written byte with bit 7 inverted.
- R7: With `hv_flag`=1 and `msel`=4'b0001, a falling edge on `prog_pin` starts an erase. `rdy` is low for ERASE_CYCLES cycles. If the strobe stays low throughout, every byte becomes FFh and both lock bits clear.
- R8: If `prog_pin` rises before an erase finishes, the erase stops and `rdy` goes high in the next cycle. The array and the lock bits are left unchanged.
- R9: `msel`=4'b1111 with a high voltage and a strobe rise sets lock bit 1 after WRITE_CYCLES cycles. After that, code-write strobes start no cycle and change nothing.
- R10: `msel`=4'b0011 sets lock bit 2 the same way. With both lock bits set, code reads return FFh. Signature reads are not affected.
- R11: A signature read returns 5Ah at address 0, 21h at address 1, C3h at address 2, and FFh at any other address.
- R12: A strobe edge that arrives while a cycle is busy starts nothing and does not lengthen the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prst_pin | input | 1 | Programming reset pin level |
| hv_flag | input | 1 | High programming voltage present on the reset pin |
| prog_pin | input | 1 | Program strobe |
| msel | input | 4 | Mode select lines a..d |
| incr_pin | input | 1 | Address increment pulse |
| din | input | 8 | Data bus input |
| dout | output | 8 | Data bus output |
| doe | output | 1 | Data bus output enable |
| rdy | output | 1 | Ready (1) / busy (0) |

## Verification
The bench aims at these corner cases:
- Wrapping the counter at the top address. A counter that fails to wrap reads the wrong byte after the step.
- A reset edge and an increment in the same cycle. A design that lets the increment win is left at address 1.
- A second write to a programmed byte. A design that overwrites instead of AND-ing shows bits set that should be clear.
- A strobe pulse in the middle of a write. A design that restarts the timer shows a busy time that is too long.
- An erase aborted early. A design that erases anyway unlocks the array and loses data.
- The lock gating. A blocked write that still starts shows `rdy` going low, and a fully locked read that leaks data returns array contents instead of FFh.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_CODE,
    OP_LOCK1,
    OP_LOCK2,
    OP_ERASE,
    OP_READ,
    OP_SIG
  } op_e;

  localparam logic [3:0] SEL_CODE  = 4'b1110;
  localparam logic [3:0] SEL_LOCK1 = 4'b1111;
  localparam logic [3:0] SEL_LOCK2 = 4'b0011;
  localparam logic [3:0] SEL_ERASE = 4'b0001;
  localparam logic [3:0] SEL_READ  = 4'b1100;
  localparam logic [3:0] SEL_SIG   = 4'b0000;

  function automatic op_e decode_op(logic rst_lvl, logic hv, logic strobe, logic [3:0] sel);
    op_e r;
    r = OP_IDLE;
    if (rst_lvl) begin
      if (hv) begin
        case (sel)
          SEL_CODE:  r = OP_CODE;
          SEL_LOCK1: r = OP_LOCK1;
          SEL_LOCK2: r = OP_LOCK2;
          SEL_ERASE: r = OP_ERASE;
          default:   r = OP_IDLE;
        endcase
      end else if (strobe) begin
        if (sel == SEL_READ)     r = OP_READ;
        else if (sel == SEL_SIG) r = OP_SIG;
      end
    end
    return r;
  endfunction

  // Programming only clears bits.
  function automatic logic [7:0] merge_byte(logic [7:0] old_b, logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // Status byte seen while a write is pending.
  function automatic logic [7:0] poll_byte(logic [7:0] d);
    return {~d[7], d[6:0]};
  endfunction

endpackage

// File: rtl/flashprog_mode_dec.sv
module flashprog_mode_dec
  import flashprog_pkg::*;
(
  input  logic       prst_pin,
  input  logic       hv_flag,
  input  logic       prog_pin,
  input  logic [3:0] msel,
  output op_e        op
);
  always_comb op = decode_op(prst_pin, hv_flag, prog_pin, msel);
endmodule

// File: rtl/flashprog_addr_ctr.sv
module flashprog_addr_ctr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_pin,
  input  logic          step_pin,
  output logic [AW-1:0] addr,
  output logic          clr_ev,
  output logic          step_ev
);
  logic clr_q, step_q;

  assign clr_ev  = clr_pin & ~clr_q;
  assign step_ev = step_pin & ~step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q  <= 1'b0;
      step_q <= 1'b0;
      addr   <= '0;
    end else begin
      clr_q  <= clr_pin;
      step_q <= step_pin;
      if (clr_ev)       addr <= '0;
      else if (step_ev) addr <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/flashprog_seq.sv
module flashprog_seq
  import flashprog_pkg::*;
#(
  parameter int WRITE_CYCLES = 2000,
  parameter int ERASE_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  op_e  op,
  input  logic strobe,
  input  logic lock1,
  output logic busy,
  output logic start_ev,
  output logic done_ev,
  output logic abort_ev,
  output op_e  cur_op
);
  localparam int MAXC = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic          strobe_q;
  logic [CW-1:0] cnt_q;
  logic          rise, fall, start_prog, start_erase;

  assign rise        = strobe & ~strobe_q;
  assign fall        = ~strobe & strobe_q;
  assign start_prog  = !busy && rise &&
                       ((op == OP_CODE && !lock1) || op == OP_LOCK1 || op == OP_LOCK2);
  assign start_erase = !busy && fall && (op == OP_ERASE);
  assign start_ev    = start_prog | start_erase;
  assign abort_ev    = busy && (cur_op == OP_ERASE) && strobe;
  assign done_ev     = busy && (cnt_q == CW'(1)) && !abort_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      busy     <= 1'b0;
      cnt_q    <= '0;
      cur_op   <= OP_IDLE;
    end else begin
      strobe_q <= strobe;
      if (start_prog) begin
        busy   <= 1'b1;
        cnt_q  <= CW'(WRITE_CYCLES);
        cur_op <= op;
      end else if (start_erase) begin
        busy   <= 1'b1;
        cnt_q  <= CW'(ERASE_CYCLES);
        cur_op <= op;
      end else if (abort_ev || done_ev) begin
        busy   <= 1'b0;
        cnt_q  <= '0;
        cur_op <= OP_IDLE;
      end else if (busy) begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/flashprog_ctrl.sv
module flashprog_ctrl
  import flashprog_pkg::*;
#(
  parameter int          DEPTH        = 1024,
  parameter int          WRITE_CYCLES = 2000,
  parameter int          ERASE_CYCLES = 10000,
  parameter logic [7:0]  SIG0         = 8'h5A,
  parameter logic [7:0]  SIG1         = 8'h21,
  parameter logic [7:0]  SIG2         = 8'hC3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prst_pin,
  input  logic       hv_flag,
  input  logic       prog_pin,
  input  logic [3:0] msel,
  input  logic       incr_pin,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       doe,
  output logic       rdy
);
  localparam int AW = $clog2(DEPTH);

  op_e           op, cur_op;
  logic [AW-1:0] addr_q, wb_addr;
  logic [7:0]    wb_data;
  logic          clr_ev, step_ev, busy, start_ev, done_ev, abort_ev;
  logic          lock1_q, lock2_q;
  logic [7:0]    mem [DEPTH];

  flashprog_mode_dec dec_i (
    .prst_pin(prst_pin), .hv_flag(hv_flag), .prog_pin(prog_pin), .msel(msel), .op(op)
  );

  flashprog_addr_ctr #(.AW(AW)) ctr_i (
    .clk(clk), .rst_n(rst_n), .clr_pin(prst_pin), .step_pin(incr_pin),
    .addr(addr_q), .clr_ev(clr_ev), .step_ev(step_ev)
  );

  flashprog_seq #(.WRITE_CYCLES(WRITE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) seq_i (
    .clk(clk), .rst_n(rst_n), .op(op), .strobe(prog_pin), .lock1(lock1_q),
    .busy(busy), .start_ev(start_ev), .done_ev(done_ev), .abort_ev(abort_ev),
    .cur_op(cur_op)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      lock1_q <= 1'b0;
      lock2_q <= 1'b0;
      wb_addr <= '0;
      wb_data <= '0;
    end else begin
      if (start_ev) begin
        wb_addr <= addr_q;
        wb_data <= din;
      end
      if (done_ev) begin
        case (cur_op)
          OP_CODE:  mem[wb_addr] <= merge_byte(mem[wb_addr], wb_data);
          OP_LOCK1: lock1_q <= 1'b1;
          OP_LOCK2: lock2_q <= 1'b1;
          OP_ERASE: begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            lock1_q <= 1'b0;
            lock2_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign rdy = ~busy;
  assign doe = (op == OP_READ) || (op == OP_SIG);

  always_comb begin
    dout = 8'h00;
    if (op == OP_SIG) begin
      case (addr_q)
        AW'(0):  dout = SIG0;
        AW'(1):  dout = SIG1;
        AW'(2):  dout = SIG2;
        default: dout = 8'hFF;
      endcase
    end else if (op == OP_READ) begin
      if (busy && cur_op == OP_CODE) dout = poll_byte(wb_data);
      else if (lock1_q && lock2_q)   dout = 8'hFF;
      else                           dout = mem[addr_q];
    end
  end
endmodule

// File: rtl/flashprog_ctrl_chk.sv
module flashprog_ctrl_chk
  import flashprog_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          clr_ev,
  input logic          step_ev,
  input logic          start_ev,
  input logic          busy,
  input logic          rdy,
  input logic          doe,
  input logic [7:0]    dout,
  input logic          prst_pin,
  input logic          hv_flag,
  input logic          prog_pin,
  input op_e           op,
  input logic          lk1,
  input logic          lk2
);
  assert_addr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> (addr == '0));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !clr_ev) |=> (addr == $past(addr) + 1'b1));

  assert_oe_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> (prst_pin && !hv_flag && prog_pin));

  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !rdy);

  assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_ev);

  assert_locked_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk1 && lk2 && !busy && op == OP_READ) |-> (dout == 8'hFF));
endmodule

bind flashprog_ctrl flashprog_ctrl_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr_q), .clr_ev(clr_ev), .step_ev(step_ev),
  .start_ev(start_ev), .busy(busy), .rdy(rdy), .doe(doe), .dout(dout),
  .prst_pin(prst_pin), .hv_flag(hv_flag), .prog_pin(prog_pin), .op(op),
  .lk1(lock1_q), .lk2(lock2_q)
);

// File: tb/flashprog_ctrl_tb_top.sv
module flashprog_ctrl_tb_top;
  localparam int WC    = 20;
  localparam int EC    = 50;
  localparam int DEPTH = 1024;

  logic       clk = 1'b0;
  logic       rst_n, prst_pin, hv_flag, prog_pin, incr_pin;
  logic [3:0] msel;
  logic [7:0] din, dout;
  logic       doe, rdy;

  always #5 clk = ~clk;

  flashprog_ctrl #(.WRITE_CYCLES(WC), .ERASE_CYCLES(EC)) dut_i (
    .clk(clk), .rst_n(rst_n), .prst_pin(prst_pin), .hv_flag(hv_flag),
    .prog_pin(prog_pin), .msel(msel), .incr_pin(incr_pin), .din(din),
    .dout(dout), .doe(doe), .rdy(rdy)
  );

  int         n_cmp = 0, n_bad = 0;
  logic [7:0] mem_m [DEPTH];
  bit         lk1_m = 0, lk2_m = 0;
  int         addr_m = 0;

  task automatic chk(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pins(bit h, bit g, logic [3:0] s);
    hv_flag = h; prog_pin = g; msel = s;
  endtask

  task automatic clr_addr();
    prst_pin = 1'b0; tick();
    prst_pin = 1'b1; tick();
    addr_m = 0;
  endtask

  task automatic step_addr(int n);
    for (int i = 0; i < n; i++) begin
      incr_pin = 1'b1; tick();
      incr_pin = 1'b0; tick();
    end
    addr_m = (addr_m + n) % DEPTH;
  endtask

  task automatic goto_addr(int a);
    if (a < addr_m) clr_addr();
    step_addr(a - addr_m);
  endtask

  function automatic logic [7:0] exp_rd(int a);
    return (lk1_m && lk2_m) ? 8'hFF : mem_m[a];
  endfunction

  function automatic logic [7:0] exp_sig(int a);
    return (a == 0) ? 8'h5A : (a == 1) ? 8'h21 : (a == 2) ? 8'hC3 : 8'hFF;
  endfunction

  task automatic run_prog(logic [3:0] s, logic [7:0] d, bit dbl, bit poll, output int cyc);
    din = d;
    pins(1, 1, s); tick();
    prog_pin = 1'b0; tick();
    prog_pin = 1'b1;
    cyc = 0;
    while (1) begin
      tick();
      if (rdy) break;
      cyc++;
      if (!dbl) begin
        if (cyc == 1 && poll) pins(0, 1, 4'b1100);
        if (cyc == 2 && poll) chk("R6 polling", dout, {~d[7], d[6:0]});
      end else begin
        if (cyc == 1) prog_pin = 1'b0;
        if (cyc == 2) prog_pin = 1'b1;
        if (cyc == 3 && poll) pins(0, 1, 4'b1100);
        if (cyc == 5 && poll) chk("R6 polling", dout, {~d[7], d[6:0]});
      end
      if (cyc > 4 * EC) break;
    end
    pins(0, 1, 4'b1100);
  endtask

  task automatic write_code(int a, logic [7:0] d, bit dbl);
    int cyc;
    goto_addr(a);
    run_prog(4'b1110, d, dbl, !lk1_m, cyc);
    if (lk1_m) chk("R9 blocked write starts no cycle", cyc, 0);
    else begin
      chk(dbl ? "R12 busy length with extra strobe" : "R5 busy length", cyc, WC);
      mem_m[a] = mem_m[a] & d;
    end
    tick();
    chk("R5 readback", dout, exp_rd(a));
  endtask

  task automatic read_chk(string req, int a);
    pins(0, 1, 4'b1100);
    goto_addr(a); tick();
    chk(req, dout, exp_rd(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    summary();
  end

  initial begin
    int cyc;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
    rst_n = 1'b0; prst_pin = 1'b0; incr_pin = 1'b0; din = 8'h00;
    pins(0, 1, 4'b0000);
    repeat (3) tick();
    rst_n = 1'b1; tick();
    chk("R1 rdy after reset", rdy, 1);
    chk("R1 doe after reset", doe, 0);
    chk("R4 dout idle", dout, 8'h00);

    pins(0, 1, 4'b1100);
    clr_addr(); tick();
    chk("R4 doe in read", doe, 1);
    chk("R1 erased byte", dout, 8'hFF);
    pins(1, 1, 4'b1100); tick();
    chk("R4 doe off with high voltage", doe, 0);
    chk("R4 dout off", dout, 8'h00);
    pins(0, 0, 4'b1100); tick();
    chk("R4 doe off with strobe low", doe, 0);

    pins(0, 1, 4'b0000);
    for (int a = 0; a < 4; a++) begin
      goto_addr(a); tick();
      chk("R11 signature", dout, exp_sig(a));
    end

    write_code(5, 8'hA7, 0);
    write_code(5, 8'h3E, 0);
    write_code(9, 8'h55, 1);
    write_code(0, 8'hF0, 0);
    write_code(1, 8'h0F, 0);

    for (int k = 0; k < 25; k++) begin
      int a, b;
      a = int'($urandom % 256);
      write_code(a, 8'($urandom), 0);
      b = int'($urandom % 256);
      read_chk("R5 random readback", b);
    end

    // Reset edge and increment in the same cycle.
    pins(0, 1, 4'b1100);
    prst_pin = 1'b0; tick();
    prst_pin = 1'b1; incr_pin = 1'b1; tick();
    incr_pin = 1'b0; tick();
    addr_m = 0;
    chk("R2 clear wins over step", dout, exp_rd(0));

    write_code(1023, 8'h66, 0);
    step_addr(1); tick();
    chk("R3 wrap to zero", dout, exp_rd(0));

    run_prog(4'b1111, 8'h00, 0, 0, cyc);
    chk("R9 lock1 cycle", cyc, WC);
    lk1_m = 1;
    write_code(20, 8'h00, 0);
    read_chk("R9 data kept after blocked write", 20);

    run_prog(4'b0011, 8'h00, 0, 0, cyc);
    chk("R10 lock2 cycle", cyc, WC);
    lk2_m = 1;
    read_chk("R10 locked read", 5);
    pins(0, 1, 4'b0000); goto_addr(1); tick();
    chk("R10 signature with locks", dout, 8'h21);

    // Erase aborted by an early strobe rise.
    pins(1, 1, 4'b0001); tick();
    prog_pin = 1'b0; tick();
    chk("R8 erase started", rdy, 0);
    tick(); tick();
    prog_pin = 1'b1; tick();
    chk("R8 abort rdy", rdy, 1);
    read_chk("R8 locks intact", 5);

    // Full erase.
    pins(1, 1, 4'b0001); tick();
    prog_pin = 1'b0; cyc = 0;
    while (1) begin
      tick();
      if (rdy) break;
      cyc++;
      if (cyc > 4 * EC) break;
    end
    prog_pin = 1'b1;
    chk("R7 erase length", cyc, EC);
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
    lk1_m = 0; lk2_m = 0;
    read_chk("R7 erased", 5);
    read_chk("R7 erased", 1023);
    write_code(5, 8'h12, 0);

    summary();
  end
endmodule